// File: doc/BRIEF.md
# Indirect Program-RAM Loader

This block moves a byte image into, or compares it against, the program RAM of an embedded microcontroller. That RAM is not directly addressable. It is reached through a small register window on a shared parallel bus: a mode register, two address bytes (high and low) and a data port. The data port advances the RAM address by itself after every byte, so the loader writes an address only when a new chunk begins. Each chunk holds at most `CHUNK` bytes.

A transfer begins with a one-cycle `start` pulse that carries the base address, the byte count and the direction: load or verify. The loader asks the bus master for ownership and waits for the grant. For each chunk it then performs these bus accesses in order:

1. Set the mode register.
2. Write the high address byte.
3. Write the low address byte.
4. Make one data-port access per byte.
5. Clear the mode register.

Image bytes arrive on a valid/ready stream. In load mode each byte is written out. In verify mode each byte is compared with the byte read back, and every difference is counted. A bus error ends the transfer at once. The block raises a one-cycle `done` pulse at the end of every transfer, together with an error flag.

Top module: `ucram_loader`

## Requirements
- R1: After reset the block is idle: `done`, `bus_req`, `txn_valid`, `bus_err` and `img_ready` are 0, and `mism_cnt` is 0.
- R2: `bus_req` is high for the whole of a non-empty transfer. No bus access is issued until `bus_gnt` is high. `bus_req` falls when `done` pulses.
- R3: Each chunk opens with these accesses, in this order: a write of the mode register (register index 0) with value 1 for load or 2 for verify, then a write of register index 2 with address bits [15:8], then a write of register index 3 with address bits [7:0]. An access stays valid, with a stable register index and data, until `txn_done`.
- R4: A chunk holds at most `CHUNK` (64) bytes, and only the last chunk may be shorter. The address written at the start of a chunk equals the base address plus the number of bytes already transferred. No address is written inside a chunk.
- R5: Every byte is one access to register index 4. In load mode `txn_rd`=0 and `txn_wdata` is the image byte. In verify mode `txn_rd`=1.
- R6: After the last data access of each chunk, the mode register (index 0) is written with 0.
- R7: In verify mode, `mism_cnt` at `done` equals the number of read-back bytes that differ from the image; a non-zero value means the verify failed. `mism_cnt` and `bus_err` are cleared by `start` and held between transfers.
- R8: An access that completes with `txn_err` ends the transfer. No further access follows, `done` pulses with `bus_err`=1, and `bus_req` drops.
- R9: A transfer with a byte count of 0 pulses `done` in the cycle after `start` and never raises `bus_req`.
- R10: Exactly one image byte is taken (`img_valid` and `img_ready` both high) for each data-port access, and the total taken equals the byte count when no error occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a transfer; sampled only while idle |
| verify | input | 1 | 1 = compare against RAM, 0 = load RAM |
| base_addr | input | 16 | First RAM address |
| byte_count | input | LEN_W | Number of bytes to transfer |
| img_valid | input | 1 | Image byte available |
| img_byte | input | 8 | Image byte |
| img_ready | output | 1 | Image byte taken when high with `img_valid` |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership granted |
| txn_valid | output | 1 | Bus access pending |
| txn_rd | output | 1 | Access is a read |
| txn_reg | output | 3 | Register index within the RAM access window |
| txn_wdata | output | 8 | Write data |
| txn_done | input | 1 | Access complete (one cycle) |
| txn_err | input | 1 | Access failed; valid with `txn_done` |
| txn_rdata | input | 8 | Read data; valid with `txn_done` |
| done | output | 1 | One-cycle end-of-transfer pulse |
| bus_err | output | 1 | Last transfer ended on a bus error |
| mism_cnt | output | CNT_W | Verify mismatch count of the last transfer |

## Verification
The bench targets these corner cases:

- **Chunk boundaries (lengths 1, 64, 65 and 130).** A design that miscounts the chunk index would either re-send the address in the middle of a chunk or let a chunk run past 64 bytes. The bus model flags a data access after the 64th byte of a chunk, and it flags any address that does not match the running byte offset.
- **Delayed grant.** A loader that skipped arbitration would show an access while the grant is low.
- **Bus errors at three points** (the first mode write, a data access, and the closing mode clear). Sloppy abort handling would show up as extra accesses after the error, or as a missing error flag.
- **Verify runs with and without corrupted bytes.** These catch a comparison against the wrong byte, which shifts the mismatch count.

// File: rtl/ucl_pkg.sv
package ucl_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_ARB, S_CSET, S_ADRH, S_ADRL, S_FETCH, S_DATA, S_CCLR, S_FIN
   } ucl_state_e;

   // register window indices; neighbours decode these
   localparam logic [2:0] REG_MODE = 3'd0;
   localparam logic [2:0] REG_ADRH = 3'd2;
   localparam logic [2:0] REG_ADRL = 3'd3;
   localparam logic [2:0] REG_PORT = 3'd4;

   localparam logic [7:0] MODE_OFF = 8'd0;
   localparam logic [7:0] MODE_WR  = 8'd1;
   localparam logic [7:0] MODE_RD  = 8'd2;

   localparam int RAM_AW = 16;

endpackage

// File: rtl/ucl_chunk_ctr.sv
module ucl_chunk_ctr #(
   parameter int LEN_W = 16,
   parameter int CHUNK = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [15:0]          base,
   input  logic [LEN_W-1:0]     len,
   input  logic                 step,
   output logic [15:0]          addr,
   output logic                 chunk_end,
   output logic                 drained
);
   localparam int IW = $clog2(CHUNK);
   localparam logic [IW-1:0] IDX_MAX = IW'(CHUNK - 1);

   generate
      if (CHUNK < 2 || CHUNK > 256) begin : g_bad_chunk
         $error("ucl_chunk_ctr: CHUNK must lie in 2..256");
      end
   endgenerate

   logic [15:0]      addr_q;
   logic [LEN_W-1:0] left_q;
   logic [IW-1:0]    idx_q;
   logic             last_all;

   assign last_all  = (left_q == LEN_W'(1));
   assign chunk_end = last_all || (idx_q == IDX_MAX);
   assign drained   = (left_q == '0);
   assign addr      = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         left_q <= '0;
         idx_q  <= '0;
      end else if (load) begin
         addr_q <= base;
         left_q <= len;
         idx_q  <= '0;
      end else if (step) begin
         addr_q <= addr_q + 16'd1;
         left_q <= left_q - LEN_W'(1);
         idx_q  <= chunk_end ? '0 : idx_q + IW'(1);
      end
   end

   // R4
   no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> !drained);

endmodule

// File: rtl/ucl_miscount.sv
module ucl_miscount #(
   parameter int CNT_W = 16,
   parameter bit SAT   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             hit,
   input  logic [7:0]       exp_byte,
   input  logic [7:0]       got_byte,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             miss;
   logic [CNT_W-1:0] cnt_q;

   assign miss = hit && (exp_byte != got_byte);
   assign cnt  = cnt_q;

   generate
      if (SAT) begin : g_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       cnt_q <= '0;
            else if (clr)                     cnt_q <= '0;
            else if (miss && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
         end
         // R7
         cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clr |=> cnt_q >= $past(cnt_q));
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt_q <= '0;
            else if (clr)  cnt_q <= '0;
            else if (miss) cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   endgenerate

   // R7
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt_q == '0);

endmodule

// File: rtl/ucram_loader.sv
module ucram_loader #(
   parameter int LEN_W = 16,
   parameter int CHUNK = 64,
   parameter int CNT_W = 16,
   parameter bit SAT   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             verify,
   input  logic [15:0]      base_addr,
   input  logic [LEN_W-1:0] byte_count,
   input  logic             img_valid,
   input  logic [7:0]       img_byte,
   output logic             img_ready,
   output logic             bus_req,
   input  logic             bus_gnt,
   output logic             txn_valid,
   output logic             txn_rd,
   output logic [2:0]       txn_reg,
   output logic [7:0]       txn_wdata,
   input  logic             txn_done,
   input  logic             txn_err,
   input  logic [7:0]       txn_rdata,
   output logic             done,
   output logic             bus_err,
   output logic [CNT_W-1:0] mism_cnt
);
   import ucl_pkg::*;

   generate
      if (LEN_W < 1 || LEN_W > 24) begin : g_bad_len
         $error("ucram_loader: LEN_W must lie in 1..24");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("ucram_loader: CNT_W must be positive");
      end
   endgenerate

   ucl_state_e  state, nxt;
   logic        mode_q;
   logic [7:0]  byte_q;
   logic        err_q;
   logic [15:0] cur_addr;
   logic        chunk_end, drained;
   logic        accept, fin_ok, step, load;

   assign load   = (state == S_IDLE) && start;
   assign accept = txn_valid && txn_done;
   assign fin_ok = accept && !txn_err;
   assign step   = (state == S_DATA) && fin_ok;

   ucl_chunk_ctr #(.LEN_W(LEN_W), .CHUNK(CHUNK)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(load), .base(base_addr),
      .len(byte_count), .step(step), .addr(cur_addr),
      .chunk_end(chunk_end), .drained(drained)
   );

   ucl_miscount #(.CNT_W(CNT_W), .SAT(SAT)) u_cmp (
      .clk(clk), .rst_n(rst_n), .clr(load), .hit(step && mode_q),
      .exp_byte(byte_q), .got_byte(txn_rdata), .cnt(mism_cnt)
   );

   always_comb begin
      nxt = state;
      case (state)
         S_IDLE:  if (start) nxt = (byte_count == '0) ? S_FIN : S_ARB;
         S_ARB:   if (bus_gnt) nxt = S_CSET;
         S_CSET:  if (accept) nxt = txn_err ? S_FIN : S_ADRH;
         S_ADRH:  if (accept) nxt = txn_err ? S_FIN : S_ADRL;
         S_ADRL:  if (accept) nxt = txn_err ? S_FIN : S_FETCH;
         S_FETCH: if (img_valid) nxt = S_DATA;
         S_DATA:  if (accept) nxt = txn_err ? S_FIN : (chunk_end ? S_CCLR : S_FETCH);
         S_CCLR:  if (accept) nxt = (txn_err || drained) ? S_FIN : S_CSET;
         S_FIN:   nxt = S_IDLE;
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         mode_q <= 1'b0;
         byte_q <= '0;
         err_q  <= 1'b0;
      end else begin
         state <= nxt;
         if (load) begin
            mode_q <= verify;
            err_q  <= 1'b0;
         end
         if (state == S_FETCH && img_valid) byte_q <= img_byte;
         if (accept && txn_err) err_q <= 1'b1;
      end
   end

   always_comb begin
      txn_valid = 1'b1;
      txn_rd    = 1'b0;
      txn_reg   = REG_MODE;
      txn_wdata = MODE_OFF;
      case (state)
         S_CSET: txn_wdata = mode_q ? MODE_RD : MODE_WR;
         S_ADRH: begin txn_reg = REG_ADRH; txn_wdata = cur_addr[15:8]; end
         S_ADRL: begin txn_reg = REG_ADRL; txn_wdata = cur_addr[7:0]; end
         S_DATA: begin
            txn_reg   = REG_PORT;
            txn_rd    = mode_q;
            txn_wdata = mode_q ? 8'h00 : byte_q;
         end
         S_CCLR: txn_wdata = MODE_OFF;
         default: txn_valid = 1'b0;
      endcase
   end

   assign img_ready = (state == S_FETCH);
   assign bus_req   = (state != S_IDLE) && (state != S_FIN);
   assign done      = (state == S_FIN);
   assign bus_err   = err_q;

   // R2
   access_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> bus_gnt);

   // R3
   txn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid && !txn_done |=> txn_valid && $stable(txn_reg) && $stable(txn_wdata));

   // R8
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept && txn_err |=> !txn_valid && done);

   // R9
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load && byte_count == '0 |=> done && !bus_req);

   // R2
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !bus_req && !txn_valid);

endmodule

// File: tb/ucram_loader_tb.sv
module ucram_loader_tb_top;
   localparam int TCLK = 10;
   localparam int CH = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, verify = 1'b0;
   logic [15:0] base_addr = '0;
   logic [15:0] byte_count = '0;
   logic img_valid = 1'b0;
   logic [7:0] img_byte = '0;
   logic img_ready, bus_req, txn_valid, txn_rd, done, bus_err;
   logic bus_gnt = 1'b0, txn_done = 1'b0, txn_err = 1'b0;
   logic [2:0] txn_reg;
   logic [7:0] txn_wdata, txn_rdata;
   logic [15:0] mism_cnt;

   always #(TCLK/2) clk = ~clk;

   ucram_loader dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .verify(verify),
      .base_addr(base_addr), .byte_count(byte_count),
      .img_valid(img_valid), .img_byte(img_byte), .img_ready(img_ready),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .txn_valid(txn_valid),
      .txn_rd(txn_rd), .txn_reg(txn_reg), .txn_wdata(txn_wdata),
      .txn_done(txn_done), .txn_err(txn_err), .txn_rdata(txn_rdata),
      .done(done), .bus_err(bus_err), .mism_cnt(mism_cnt)
   );

   int n_chk = 0, n_bad = 0;
   logic [7:0] img_buf [0:1023];
   logic [7:0] mem [0:1023];

   // model state
   int  img_idx = 0, txn_n = 0, viol = 0, done_b = 0, chunk_b = 0;
   int  phase = 0, lat = 0, gnt_cnt = 0, gnt_delay = 0, err_at = -1;
   bit  exp_mode = 0, req_seen = 0;
   int  op_len = 0;
   logic [15:0] op_base = '0, ptr = '0;
   logic [7:0] hi_q = '0;

   task automatic check_eq(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_txns(input int len);
      return 4 * ((len + CH - 1) / CH) + len;
   endfunction

   always @(posedge clk) if (img_valid && img_ready) img_idx = img_idx + 1;

   always @(negedge clk) begin
      img_valid = ($urandom % 4) != 0;
      img_byte  = img_buf[img_idx % 1024];
      if (bus_req) begin
         req_seen = 1;
         if (gnt_cnt >= gnt_delay) bus_gnt = 1'b1; else gnt_cnt++;
      end else begin
         bus_gnt = 1'b0;
         gnt_cnt = 0;
      end
      if (txn_done) begin
         txn_done = 1'b0;
         txn_err  = 1'b0;
      end else if (txn_valid) begin
         if (!bus_gnt) viol++;
         if (lat > 0) lat--;
         else begin
            lat = $urandom % 4;
            txn_done = 1'b1;
            if (txn_n == err_at) txn_err = 1'b1;
            else begin
               case (txn_reg)
                  3'd0: begin
                     if (txn_wdata != 0) begin
                        if (phase != 0 || txn_wdata != (exp_mode ? 8'd2 : 8'd1)) viol++;
                        phase = 1;
                     end else begin
                        if (phase != 3) viol++;
                        if (chunk_b != ((op_len - done_b + chunk_b) < CH ?
                                        (op_len - done_b + chunk_b) : CH)) viol++;
                        phase = 0;
                     end
                  end
                  3'd2: begin if (phase != 1) viol++; hi_q = txn_wdata; phase = 2; end
                  3'd3: begin
                     if (phase != 2) viol++;
                     ptr = {hi_q, txn_wdata};
                     if (ptr != op_base + 16'(done_b)) viol++;
                     phase = 3; chunk_b = 0;
                  end
                  3'd4: begin
                     if (phase != 3 || chunk_b >= CH || txn_rd != exp_mode) viol++;
                     if (exp_mode) txn_rdata = mem[ptr[9:0]];
                     else mem[ptr[9:0]] = txn_wdata;
                     ptr = ptr + 16'd1; done_b++; chunk_b++;
                  end
                  default: viol++;
               endcase
            end
            txn_n++;
         end
      end
   end

   task automatic run_op(input bit vmode, input logic [15:0] base, input int len,
                         input int gdel, input int eat, input int exp_mis, input string nm);
      int cyc;
      int n_now;
      int bad;
      @(negedge clk);
      img_idx = 0; txn_n = 0; viol = 0; done_b = 0; chunk_b = 0; phase = 0;
      gnt_delay = gdel; err_at = eat; exp_mode = vmode; req_seen = 0;
      op_len = len; op_base = base;
      start = 1'b1; verify = vmode; base_addr = base; byte_count = 16'(len);
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL %s watchdog actual=%0d expected=%0d", nm, cyc, 0);
         return;
      end
      check_eq({nm, " R2 req low at done"}, int'(bus_req), 0);
      check_eq({nm, " R3/R4/R5/R6 protocol violations"}, viol, 0);
      check_eq({nm, " R8 bus_err"}, int'(bus_err), eat >= 0 ? 1 : 0);
      if (eat < 0) begin
         check_eq({nm, " R4 access count"}, txn_n, exp_txns(len));
         check_eq({nm, " R10 bytes taken"}, img_idx, len);
         check_eq({nm, " R7 mismatches"}, int'(mism_cnt), exp_mis);
         if (!vmode) begin
            bad = 0;
            for (int i = 0; i < len; i++)
               if (mem[(int'(base) + i) % 1024] != img_buf[i]) bad++;
            check_eq({nm, " R5 ram contents"}, bad, 0);
         end
      end else begin
         check_eq({nm, " R8 accesses up to error"}, txn_n, eat + 1);
      end
      if (len == 0) check_eq({nm, " R9 no request"}, int'(req_seen), 0);
      n_now = txn_n;
      repeat (4) @(negedge clk);
      check_eq({nm, " R8 no access after done"}, txn_n, n_now);
      check_eq({nm, " R7 count held"}, int'(mism_cnt), eat < 0 ? exp_mis : int'(mism_cnt));
   endtask

   task automatic prep_verify(input logic [15:0] base, input int len, input int ncor);
      for (int i = 0; i < len; i++)
         mem[(int'(base) + i) % 1024] = img_buf[i] ^ ((i % 23 == 5 && i / 23 < ncor) ? 8'h3C : 8'h00);
   endtask

   initial begin : wd
      repeat (190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL global watchdog actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 1024; i++) begin img_buf[i] = 8'($urandom); mem[i] = 8'h00; end
      repeat (3) @(negedge clk);
      // R1 reset state
      check_eq("R1 done", int'(done), 0);
      check_eq("R1 bus_req", int'(bus_req), 0);
      check_eq("R1 txn_valid", int'(txn_valid), 0);
      check_eq("R1 bus_err", int'(bus_err), 0);
      check_eq("R1 img_ready", int'(img_ready), 0);
      check_eq("R1 mism_cnt", int'(mism_cnt), 0);
      rst_n = 1'b1;
      run_op(0, 16'h0040, 0, 0, -1, 0, "zero-len R9");
      run_op(0, 16'h0100, 1, 0, -1, 0, "write1");
      run_op(0, 16'h03C0, 64, 1, -1, 0, "write64");
      run_op(0, 16'h0201, 65, 7, -1, 0, "write65 late-grant");
      run_op(0, 16'h1233, 130, 2, -1, 0, "write130");
      for (int k = 0; k < 3; k++) begin
         int l;
         l = 1 + int'($urandom % 200);
         run_op(0, 16'($urandom), l, int'($urandom % 5), -1, 0, "write-rand");
      end
      prep_verify(16'h0010, 100, 0);
      run_op(1, 16'h0010, 100, 0, -1, 0, "verify-clean");
      prep_verify(16'h0150, 70, 3);
      run_op(1, 16'h0150, 70, 3, -1, 3, "verify-3bad");
      run_op(0, 16'h0080, 20, 0, 10, 0, "err-data");
      run_op(1, 16'h0080, 20, 0, 0, 0, "err-first");
      run_op(0, 16'h0300, 64, 0, 67, 0, "err-clear");
      prep_verify(16'h0050, 1, 1);
      run_op(1, 16'h0050, 1, 0, -1, 0, "verify1-clean");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule